// File: doc/BRIEF.md
# Burst Frame Sequencer

This block owns the reference counter of a time-division controller and decides when frames run. Once enabled it arms and waits for a synchronization pulse. It then counts a programmable startup delay and runs frames of a programmable length back to back. Each completed frame is counted against a programmable burst length. A burst length of zero runs frames for as long as the enable stays high.

The counter value, the state code, a one-cycle end-of-frame strobe and a running flag are registered outputs. Channel waveform generators downstream compare the counter against their own set and reset offsets. Frame length, startup delay and burst length are captured only while the block is disabled. A sync-clear mode can be switched at any time. When it is on, a sync pulse in the delay or frame phase pulls the counter back to zero.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `seq_state` is 0 (idle), `ref_count` is 0, and `frame_end` and `running` are low.
- R2: State codes are idle=0, armed=1, waiting=2, running=3. From idle with `enable` high, `seq_state` becomes 1 one clock later, unless a finite burst has already completed (see R6).
- R3: In the armed state the block holds with `ref_count`=0 until `sync_pulse` is sampled high. It then goes to waiting with `ref_count`=0, or straight to running if the captured startup delay is 0.
- R4: The waiting state lasts exactly D cycles for a captured delay D≥1, with `ref_count` stepping 0,1,…,D-1. The block then enters running with `ref_count`=0.
- R5: In running, `ref_count` steps 0..L-1 and wraps to 0, where L is the captured frame length (0 is treated as 1). `frame_end` is high exactly in the cycles where `seq_state`=3 and `ref_count`=L-1. `running` is high exactly when `seq_state`=3.
- R6: With a nonzero captured burst length B, the cycle after the B-th frame end returns the block to idle. It stays idle while `enable` remains high. With B=0, frames repeat without limit.
- R7: When `sync_clear_mode` is high, a `sync_pulse` sampled in waiting or running sets `ref_count` to 0 on the next cycle without changing the state. In running, that cycle does not count as a frame end even if the count was at L-1.
- R8: `enable` sampled low in any state gives `seq_state`=0 and `ref_count`=0 on the next cycle. It also clears the frame tally and the burst-complete condition.
- R9: `frame_len`, `start_delay` and `burst_len` are captured on every clock where `enable` is low. Changes made while `enable` is high have no effect until the block is next disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; low forces idle |
| sync_pulse | input | 1 | Synchronization event, one cycle per event |
| sync_clear_mode | input | 1 | When high, sync events in waiting/running zero the counter |
| frame_len | input | CNT_W | Frame length in cycles (0 treated as 1) |
| start_delay | input | CNT_W | Startup delay in cycles |
| burst_len | input | BURST_W | Frames per burst, 0 = endless |
| ref_count | output | CNT_W | Reference counter |
| seq_state | output | 2 | State code |
| frame_end | output | 1 | High in the last cycle of each frame |
| running | output | 1 | High while frames are running |

## Verification
Directed sequences come first. They cover a short delay with a two-frame burst, a zero delay, a one-cycle frame, an endless burst, sync clearing in the delay and frame phases, and configuration changes made while enabled. Each sequence isolates one ordering rule: the armed-to-running shortcut, strobe placement at the wrap, whether the burst limit holds the block idle, and which sync events reset the counter. A long random stretch follows. It uses small frame, delay and burst values, sparse sync pulses, a toggled clear mode and occasional enable drops, so that wraps, burst ends, sync clears and disables fall on the same cycles in many combinations. A cycle-level expected model checks every output in every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/burst_seq_cfg.sv
// Captures the timing configuration while the sequencer is disabled.
module burst_seq_cfg #(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [CNT_W-1:0]   frame_len_i,
  input  logic [CNT_W-1:0]   delay_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic [CNT_W-1:0]   frame_last_o,
  output logic [CNT_W-1:0]   delay_o,
  output logic [BURST_W-1:0] burst_o
);
  logic [CNT_W-1:0] last_d;

  // last counter value of a frame; a zero length behaves as one cycle
  always_comb begin
    if (frame_len_i == '0) last_d = '0;
    else                   last_d = frame_len_i - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_last_o <= '0;
      delay_o      <= '0;
      burst_o      <= '0;
    end else if (!enable) begin
      frame_last_o <= last_d;
      delay_o      <= delay_i;
      burst_o      <= burst_i;
    end
  end
endmodule

// File: rtl/burst_seq_timer.sv
// Reference counter with clear and advance controls.
module burst_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o
);
  always_comb begin
    if (clr)      count_nxt_o = '0;
    else if (inc) count_nxt_o = count_o + 1'b1;
    else          count_nxt_o = count_o;
  end

  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_nxt_o;
  end
endmodule

// File: rtl/burst_seq_fsm.sv
// Four-state sequencing, frame tally and registered status outputs.
module burst_seq_fsm
  import burst_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               sync_pulse,
  input  logic               sync_clear_mode,
  input  logic [CNT_W-1:0]   count_q,
  input  logic [CNT_W-1:0]   count_nxt,
  input  logic [CNT_W-1:0]   frame_last,
  input  logic [CNT_W-1:0]   delay,
  input  logic [BURST_W-1:0] burst,
  output logic               clr,
  output logic               inc,
  output seq_state_t         state_o,
  output logic               frame_end_o,
  output logic               running_o
);
  seq_state_t         st_q, st_d;
  logic [BURST_W-1:0] frames_q, frames_d;
  logic               done_q, done_d;
  logic               sync_clr, delay_end, frame_wrap, burst_hit;
  logic [CNT_W-1:0]   delay_last;
  logic [BURST_W-1:0] frames_inc;

  assign delay_last = delay - 1'b1;
  assign frames_inc = frames_q + 1'b1;
  assign sync_clr   = sync_clear_mode && sync_pulse &&
                      ((st_q == ST_WAIT) || (st_q == ST_RUN));
  assign delay_end  = (count_q == delay_last);
  assign frame_wrap = (count_q == frame_last);
  assign burst_hit  = (burst != '0) && (frames_inc == burst);

  always_comb begin
    st_d     = st_q;
    frames_d = frames_q;
    done_d   = done_q;
    clr      = 1'b0;
    inc      = 1'b0;
    if (!enable) begin
      st_d     = ST_IDLE;
      frames_d = '0;
      done_d   = 1'b0;
      clr      = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          clr = 1'b1;
          if (!done_q) st_d = ST_ARMED;
        end
        ST_ARMED: begin
          clr = 1'b1;
          if (sync_pulse) st_d = (delay == '0) ? ST_RUN : ST_WAIT;
        end
        ST_WAIT: begin
          if (sync_clr) begin
            clr = 1'b1;
          end else if (delay_end) begin
            clr  = 1'b1;
            st_d = ST_RUN;
          end else begin
            inc = 1'b1;
          end
        end
        ST_RUN: begin
          if (sync_clr) begin
            clr = 1'b1;
          end else if (frame_wrap) begin
            clr = 1'b1;
            if (burst_hit) begin
              st_d     = ST_IDLE;
              done_d   = 1'b1;
              frames_d = '0;
            end else begin
              frames_d = frames_inc;
            end
          end else begin
            inc = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      frames_q    <= '0;
      done_q      <= 1'b0;
      frame_end_o <= 1'b0;
      running_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      frames_q    <= frames_d;
      done_q      <= done_d;
      frame_end_o <= (st_d == ST_RUN) && (count_nxt == frame_last);
      running_o   <= (st_d == ST_RUN);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               sync_pulse,
  input  logic               sync_clear_mode,
  input  logic [CNT_W-1:0]   frame_len,
  input  logic [CNT_W-1:0]   start_delay,
  input  logic [BURST_W-1:0] burst_len,
  output logic [CNT_W-1:0]   ref_count,
  output logic [1:0]         seq_state,
  output logic               frame_end,
  output logic               running
);
  logic [CNT_W-1:0]   frame_last, delay_q, count_nxt;
  logic [BURST_W-1:0] burst_q;
  logic               clr, inc;
  seq_state_t         st;

  burst_seq_cfg #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable),
    .frame_len_i(frame_len), .delay_i(start_delay), .burst_i(burst_len),
    .frame_last_o(frame_last), .delay_o(delay_q), .burst_o(burst_q)
  );

  burst_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc),
    .count_o(ref_count), .count_nxt_o(count_nxt)
  );

  burst_seq_fsm #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .sync_pulse(sync_pulse),
    .sync_clear_mode(sync_clear_mode), .count_q(ref_count),
    .count_nxt(count_nxt), .frame_last(frame_last), .delay(delay_q),
    .burst(burst_q), .clr(clr), .inc(inc), .state_o(st),
    .frame_end_o(frame_end), .running_o(running)
  );

  assign seq_state = st;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             sync_pulse,
  input logic             sync_clear_mode,
  input logic [CNT_W-1:0] ref_count,
  input logic [1:0]       seq_state,
  input logic             frame_end,
  input logic             running
);
  AST_RUN_FLAG: assert property (@(posedge clk) disable iff (rst)
    running == (seq_state == 2'd3)); // R5

  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (seq_state == 2'd3)); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (seq_state == 2'd0) && (ref_count == '0)); // R8

  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 2'd1) && enable && !sync_pulse |=> (seq_state == 2'd1)); // R3

  AST_ARMED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 2'd1) |-> (ref_count == '0)); // R3

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 2'd0) |=> (seq_state == 2'd0) || (seq_state == 2'd1)); // R2

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (rst)
    sync_clear_mode && sync_pulse && seq_state[1] |=> (ref_count == '0)); // R7

  AST_SYNC_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    enable && sync_clear_mode && sync_pulse && seq_state[1]
      |=> (seq_state == $past(seq_state))); // R7
endmodule

bind burst_seq burst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .sync_pulse(sync_pulse),
  .sync_clear_mode(sync_clear_mode), .ref_count(ref_count),
  .seq_state(seq_state), .frame_end(frame_end), .running(running)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  localparam int CNT_W   = 16;
  localparam int BURST_W = 8;

  logic               clk = 1'b0;
  logic               rst;
  logic               enable, sync_pulse, sync_clear_mode;
  logic [CNT_W-1:0]   frame_len, start_delay;
  logic [BURST_W-1:0] burst_len;
  logic [CNT_W-1:0]   ref_count;
  logic [1:0]         seq_state;
  logic               frame_end, running;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected model state
  int m_st, m_cnt, m_frm, m_done, m_fe;
  int c_len, c_del, c_bur;

  always #4 clk = ~clk;

  burst_seq #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .sync_pulse(sync_pulse),
    .sync_clear_mode(sync_clear_mode), .frame_len(frame_len),
    .start_delay(start_delay), .burst_len(burst_len),
    .ref_count(ref_count), .seq_state(seq_state),
    .frame_end(frame_end), .running(running)
  );

  function automatic int frame_last(input int len);
    return (len == 0) ? 0 : len - 1;
  endfunction

  // one clock of the expected behaviour, from the requirements
  task automatic model_step();
    int last;
    bit sclr;
    last = frame_last(c_len);
    sclr = sync_clear_mode && sync_pulse && (m_st == 2 || m_st == 3);
    if (!enable) begin
      m_st = 0; m_cnt = 0; m_frm = 0; m_done = 0;              // R8
    end else begin
      case (m_st)
        0: begin m_cnt = 0; if (!m_done) m_st = 1; end          // R2
        1: begin m_cnt = 0; if (sync_pulse) m_st = (c_del == 0) ? 3 : 2; end // R3
        2: begin                                                // R4
          if (sclr) m_cnt = 0;
          else if (m_cnt == c_del - 1) begin m_st = 3; m_cnt = 0; end
          else m_cnt++;
        end
        default: begin                                          // R5 R6
          if (sclr) m_cnt = 0;
          else if (m_cnt == last) begin
            m_cnt = 0;
            if (c_bur != 0 && ((m_frm + 1) % 256) == c_bur) begin
              m_st = 0; m_done = 1; m_frm = 0;
            end else m_frm = (m_frm + 1) % 256;
          end else m_cnt++;
        end
      endcase
    end
    m_fe = (m_st == 3 && m_cnt == last) ? 1 : 0;
    if (!enable) begin                                          // R9
      c_len = int'(frame_len); c_del = int'(start_delay); c_bur = int'(burst_len);
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (int'(seq_state) != m_st || int'(ref_count) != m_cnt ||
        int'(frame_end) != m_fe || int'(running) != (m_st == 3 ? 1 : 0)) begin
      n_bad++;
      $display("FAIL %s t=%0t actual st=%0d cnt=%0d fe=%0b run=%0b expected st=%0d cnt=%0d fe=%0d run=%0d",
               tag, $time, seq_state, ref_count, frame_end, running,
               m_st, m_cnt, m_fe, (m_st == 3));
    end
  endtask

  // inputs are set at a falling edge before calling
  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    sync_pulse = 1'b0;
  endtask

  task automatic cfg(input int l, input int d, input int b);
    frame_len = CNT_W'(l); start_delay = CNT_W'(d); burst_len = BURST_W'(b);
  endtask

  task automatic idle_cycles(input int n, input string tag);
    enable = 1'b0;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic run_cycles(input int n, input string tag);
    enable = 1'b1;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic fire_sync(input string tag);
    sync_pulse = 1'b1;
    tick(tag);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; enable = 1'b0; sync_pulse = 1'b0; sync_clear_mode = 1'b0;
    cfg(0, 0, 0);
    m_st = 0; m_cnt = 0; m_frm = 0; m_done = 0; m_fe = 0;
    c_len = 0; c_del = 0; c_bur = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst = 1'b0;
    tick("R1 after reset");

    // delay 3, frame 4, burst 2
    cfg(4, 3, 2);
    idle_cycles(2, "R9 capture");
    run_cycles(3, "R3 armed wait");
    fire_sync("R3 sync to waiting");
    run_cycles(3, "R4 startup delay");
    run_cycles(8, "R5 frames");
    run_cycles(5, "R6 burst held idle");

    // zero delay goes straight to running; one-cycle frames
    cfg(1, 0, 3);
    idle_cycles(2, "R8 disable");
    run_cycles(2, "R2 arm");
    fire_sync("R3 zero delay");
    run_cycles(5, "R5 single-cycle frame");

    // endless burst with sync clearing, config changes ignored
    cfg(5, 2, 0);
    idle_cycles(1, "R8 disable mid");
    run_cycles(1, "R2 arm");
    fire_sync("R3 sync");
    sync_clear_mode = 1'b1;
    run_cycles(1, "R4 delay");
    fire_sync("R7 clear in waiting");
    run_cycles(4, "R7 delay restart");
    cfg(9, 7, 1);
    run_cycles(3, "R9 ignored while enabled");
    fire_sync("R7 clear in running");
    run_cycles(30, "R6 endless");
    sync_clear_mode = 1'b0;
    fire_sync("R7 mode off");
    run_cycles(6, "R5 continue");

    // random stretch
    for (int i = 0; i < 6000; i++) begin
      enable = (($urandom % 64) != 0);
      sync_pulse = (($urandom % 8) == 0);
      if (($urandom % 32) == 0) sync_clear_mode = ~sync_clear_mode;
      cfg($urandom % 8, $urandom % 6, $urandom % 4);
      tick("R5 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule